// File: doc/BRIEF.md
# BCD Alarm Time Setter

This block keeps an alarm time as four binary-coded-decimal digits: tens and units of the hour, and tens and units of the minute. A set button moves an edit cursor through three modes in a fixed loop: idle, hour editing, minute editing, and back to idle. In an editing mode, an up button and a down button step the selected field by one. Hours wrap between 23 and 00. Minutes wrap between 59 and 00. In idle, neither button has any effect.

The stored value never leaves BCD form. Because of this, it can be compared digit for digit with a wall-clock time that also arrives in BCD, and no divider or modulo logic is needed. The buzzer output is asserted while the two times agree and the alarm is enabled. All three buttons are sampled on the system clock. Each press is turned into a single one-cycle event by comparing the button's level with its registered previous level. Debouncing, display driving and timekeeping belong to other blocks.

Top module: `alarm_bcd_setter`

## Requirements
- R1: While `rst_n` is low and after it returns high, the mode is idle (code 0) and the stored alarm is 00:00.
- R2: Each rising edge of `set_btn` advances `mode_o` along idle (0), hour edit (1), minute edit (2), then idle (0) again. The new mode is visible after the clock edge that samples the rise. A button held high advances the mode only once.
- R3: In hour edit, an up press adds one hour. The units digit rolls from 9 to 0 with a carry into the tens digit (09 becomes 10), and 23 becomes 00.
- R4: In hour edit, a down press subtracts one hour. 10 becomes 09, and 00 becomes 23.
- R5: In minute edit, an up press adds one minute. 09 becomes 10, and 59 becomes 00.
- R6: In minute edit, a down press subtracts one minute. 10 becomes 09, and 00 becomes 59.
- R7: In idle mode, up and down presses leave all four alarm digits unchanged.
- R8: When rising edges of up and down are sampled on the same clock edge, the stored time does not change.
- R9: An up or down button held high for several cycles steps the field only once.
- R10: `buzzer` is high exactly when `alarm_en` is high and all four alarm digits equal the four current-time digits. The output is combinational from the stored value and the inputs.
- R11: Editing hours never changes the minute digits, and editing minutes never changes the hour digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_btn | input | 1 | Mode-advance button level |
| inc_btn | input | 1 | Up button level |
| dec_btn | input | 1 | Down button level |
| alarm_en | input | 1 | Alarm enable |
| cur_hr_tens | input | 4 | Current time, hour tens digit (BCD) |
| cur_hr_ones | input | 4 | Current time, hour units digit (BCD) |
| cur_min_tens | input | 4 | Current time, minute tens digit (BCD) |
| cur_min_ones | input | 4 | Current time, minute units digit (BCD) |
| alm_hr_tens | output | 4 | Stored alarm, hour tens digit |
| alm_hr_ones | output | 4 | Stored alarm, hour units digit |
| alm_min_tens | output | 4 | Stored alarm, minute tens digit |
| alm_min_ones | output | 4 | Stored alarm, minute units digit |
| mode_o | output | 2 | Edit mode: 0 idle, 1 hours, 2 minutes |
| buzzer | output | 1 | Alarm match indication |

## Verification
The assertions assume that the button levels are already clean and synchronous to `clk`. They also assume that reset is applied before the first press, so that the stored digits always start from a legal BCD time. The stimulus drives every button change half a period away from the sampling edge. It keeps the current-time inputs at valid BCD values, because the range checks cover only the stored value. Held presses and simultaneous up/down presses are applied on purpose, so that the single-event and conflict rules are exercised within these limits.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_HOUR = 2'd1,
    MODE_MIN  = 2'd2
  } mode_e;

  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] ones;
  } bcd2_t;

  // Fixed loop of edit modes driven by the set button.
  function automatic mode_e mode_after(mode_e m);
    case (m)
      MODE_IDLE: return MODE_HOUR;
      MODE_HOUR: return MODE_MIN;
      default:   return MODE_IDLE;
    endcase
  endfunction

  // One step up inside 00..lim, staying in BCD.
  function automatic bcd2_t bcd2_up(bcd2_t v, bcd2_t lim);
    bcd2_t r;
    if (v == lim) begin
      r = '0;
    end else if (v.ones == 4'd9) begin
      r.tens = v.tens + 4'd1;
      r.ones = 4'd0;
    end else begin
      r.tens = v.tens;
      r.ones = v.ones + 4'd1;
    end
    return r;
  endfunction

  // One step down inside 00..lim, staying in BCD.
  function automatic bcd2_t bcd2_down(bcd2_t v, bcd2_t lim);
    bcd2_t r;
    if (v == '0) begin
      r = lim;
    end else if (v.ones == 4'd0) begin
      r.tens = v.tens - 4'd1;
      r.ones = 4'd9;
    end else begin
      r.tens = v.tens;
      r.ones = v.ones - 4'd1;
    end
    return r;
  endfunction

  function automatic logic bcd2_le(bcd2_t v, bcd2_t lim);
    return (v.ones <= 4'd9) &&
           ((v.tens < lim.tens) || ((v.tens == lim.tens) && (v.ones <= lim.ones)));
  endfunction

endpackage

// File: rtl/btn_rise.sv
module btn_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign pulse = level & ~prev_q;

  // R9 / R2: a held level yields one event only
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/alarm_mode_seq.sv
module alarm_mode_seq
  import alarm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  output mode_e mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= MODE_IDLE;
    else if (advance) mode_q <= mode_after(mode_q);
  end

  a_r2_idle_to_hour: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && mode_q == MODE_IDLE) |=> (mode_q == MODE_HOUR));
  a_r2_hour_to_min: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && mode_q == MODE_HOUR) |=> (mode_q == MODE_MIN));
  a_r2_min_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && mode_q == MODE_MIN) |=> (mode_q == MODE_IDLE));
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(mode_q));
  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'd3);
endmodule

// File: rtl/bcd_alarm_store.sv
module bcd_alarm_store
  import alarm_pkg::*;
#(
  parameter int HOUR_LIMIT   = 23,
  parameter int MINUTE_LIMIT = 59
) (
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  logic  up_evt,
  input  logic  dn_evt,
  output bcd2_t hour_q,
  output bcd2_t min_q
);
  localparam bcd2_t HOUR_TOP = '{tens: 4'(HOUR_LIMIT / 10),   ones: 4'(HOUR_LIMIT % 10)};
  localparam bcd2_t MIN_TOP  = '{tens: 4'(MINUTE_LIMIT / 10), ones: 4'(MINUTE_LIMIT % 10)};

  // Named events for the assertions
  logic step_up, step_dn, hour_edit, min_edit;
  assign step_up   = up_evt & ~dn_evt;
  assign step_dn   = dn_evt & ~up_evt;
  assign hour_edit = (mode == MODE_HOUR);
  assign min_edit  = (mode == MODE_MIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hour_q <= '0;
      min_q  <= '0;
    end else begin
      if (hour_edit && step_up) hour_q <= bcd2_up(hour_q, HOUR_TOP);
      if (hour_edit && step_dn) hour_q <= bcd2_down(hour_q, HOUR_TOP);
      if (min_edit && step_up)  min_q  <= bcd2_up(min_q, MIN_TOP);
      if (min_edit && step_dn)  min_q  <= bcd2_down(min_q, MIN_TOP);
    end
  end

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE) |=> ($stable(hour_q) && $stable(min_q)));
  a_r8_conflict_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up_evt && dn_evt) |=> ($stable(hour_q) && $stable(min_q)));
  a_r11_min_kept: assert property (@(posedge clk) disable iff (!rst_n)
    hour_edit |=> $stable(min_q));
  a_r11_hour_kept: assert property (@(posedge clk) disable iff (!rst_n)
    min_edit |=> $stable(hour_q));
  a_r3_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
    bcd2_le(hour_q, HOUR_TOP));
  a_r5_min_range: assert property (@(posedge clk) disable iff (!rst_n)
    bcd2_le(min_q, MIN_TOP));
  a_r3_hour_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_edit && step_up && hour_q == HOUR_TOP) |=> (hour_q == '0));
  a_r4_hour_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_edit && step_dn && hour_q == '0) |=> (hour_q == HOUR_TOP));
endmodule

// File: rtl/alarm_bcd_setter.sv
module alarm_bcd_setter
  import alarm_pkg::*;
#(
  parameter int HOUR_LIMIT   = 23,
  parameter int MINUTE_LIMIT = 59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_btn,
  input  logic       inc_btn,
  input  logic       dec_btn,
  input  logic       alarm_en,
  input  logic [3:0] cur_hr_tens,
  input  logic [3:0] cur_hr_ones,
  input  logic [3:0] cur_min_tens,
  input  logic [3:0] cur_min_ones,
  output logic [3:0] alm_hr_tens,
  output logic [3:0] alm_hr_ones,
  output logic [3:0] alm_min_tens,
  output logic [3:0] alm_min_ones,
  output logic [1:0] mode_o,
  output logic       buzzer
);
  localparam int NUM_BTN = 3;

  logic [NUM_BTN-1:0] btn_lvl, btn_evt;
  assign btn_lvl = {dec_btn, inc_btn, set_btn};

  for (genvar g = 0; g < NUM_BTN; g++) begin : g_edge
    btn_rise u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .level (btn_lvl[g]),
      .pulse (btn_evt[g])
    );
  end

  mode_e mode_q;
  bcd2_t hour_q, min_q;

  alarm_mode_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (btn_evt[0]),
    .mode_q  (mode_q)
  );

  bcd_alarm_store #(
    .HOUR_LIMIT   (HOUR_LIMIT),
    .MINUTE_LIMIT (MINUTE_LIMIT)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode_q),
    .up_evt (btn_evt[1]),
    .dn_evt (btn_evt[2]),
    .hour_q (hour_q),
    .min_q  (min_q)
  );

  logic time_match;
  assign time_match = (hour_q == {cur_hr_tens, cur_hr_ones}) &&
                      (min_q  == {cur_min_tens, cur_min_ones});

  assign buzzer       = time_match & alarm_en;
  assign alm_hr_tens  = hour_q.tens;
  assign alm_hr_ones  = hour_q.ones;
  assign alm_min_tens = min_q.tens;
  assign alm_min_ones = min_q.ones;
  assign mode_o       = mode_q;

  a_r10_buzz_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    buzzer |-> alarm_en);
  a_r10_buzz_minute_units: assert property (@(posedge clk) disable iff (!rst_n)
    buzzer |-> (alm_min_ones == cur_min_ones));
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (mode_o == 2'd0 && alm_hr_tens == 4'd0 && alm_min_ones == 4'd0));
endmodule

// File: tb/alarm_bcd_setter_bench.sv
module alarm_bcd_setter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_btn = 1'b0, inc_btn = 1'b0, dec_btn = 1'b0, alarm_en = 1'b0;
  logic [3:0] cur_hr_tens, cur_hr_ones, cur_min_tens, cur_min_ones;
  logic [3:0] alm_hr_tens, alm_hr_ones, alm_min_tens, alm_min_ones;
  logic [1:0] mode_o;
  logic       buzzer;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_bcd_setter u_alarm_bcd_setter (
    .clk(clk), .rst_n(rst_n), .set_btn(set_btn), .inc_btn(inc_btn),
    .dec_btn(dec_btn), .alarm_en(alarm_en),
    .cur_hr_tens(cur_hr_tens), .cur_hr_ones(cur_hr_ones),
    .cur_min_tens(cur_min_tens), .cur_min_ones(cur_min_ones),
    .alm_hr_tens(alm_hr_tens), .alm_hr_ones(alm_hr_ones),
    .alm_min_tens(alm_min_tens), .alm_min_ones(alm_min_ones),
    .mode_o(mode_o), .buzzer(buzzer)
  );

  typedef struct {
    string tag;
    int    mode;
    int    hr;
    int    mn;
    bit    buzz;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  // Reference model kept as plain integers
  int m_mode = 0, m_hr = 0, m_mn = 0;
  int c_hr = 12, c_mn = 34;

  task automatic drive_cur(input int h, input int m);
    c_hr = h; c_mn = m;
    cur_hr_tens  = 4'(h / 10); cur_hr_ones  = 4'(h % 10);
    cur_min_tens = 4'(m / 10); cur_min_ones = 4'(m % 10);
  endtask

  task automatic push(input string tag);
    exp_t e;
    e.tag  = tag;
    e.mode = m_mode;
    e.hr   = m_hr;
    e.mn   = m_mn;
    e.buzz = alarm_en && (c_hr == m_hr) && (c_mn == m_mn);
    q.push_back(e);
    -> chk_ev;
  endtask

  // Monitor: compares design outputs against queued expectations
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        int hr_act, mn_act;
        e = q.pop_front();
        hr_act = int'(alm_hr_tens) * 10 + int'(alm_hr_ones);
        mn_act = int'(alm_min_tens) * 10 + int'(alm_min_ones);
        n_cmp++;
        if (int'(mode_o) != e.mode || hr_act != e.hr || mn_act != e.mn || buzzer != e.buzz) begin
          n_bad++;
          $display("FAIL %s: actual mode=%0d time=%0d:%0d buzz=%0b expected mode=%0d time=%0d:%0d buzz=%0b",
                   e.tag, mode_o, hr_act, mn_act, buzzer, e.mode, e.hr, e.mn, e.buzz);
        end
      end
    end
  end

  task automatic model_apply(input bit s, input bit i, input bit d);
    if (i != d) begin
      if (m_mode == 1) m_hr = (m_hr + (i ? 1 : 23)) % 24;
      if (m_mode == 2) m_mn = (m_mn + (i ? 1 : 59)) % 60;
    end
    if (s) m_mode = (m_mode + 1) % 3;
  endtask

  // Driver: press buttons, hold for some cycles, release
  task automatic press(input bit s, input bit i, input bit d, input int hold, input string tag);
    @(negedge clk);
    set_btn = s; inc_btn = i; dec_btn = d;
    @(posedge clk);
    model_apply(s, i, d);
    #1 push(tag);
    for (int k = 1; k < hold; k++) begin
      @(posedge clk); #1 push(tag);
    end
    @(negedge clk);
    set_btn = 1'b0; inc_btn = 1'b0; dec_btn = 1'b0;
    @(posedge clk); #1 push(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    m_mode = 0; m_hr = 0; m_mn = 0;
    repeat (2) @(posedge clk);
    #1 push(tag);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1 push(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    drive_cur(12, 34);
    do_reset("R1 reset state");

    press(1, 0, 0, 1, "R2 idle to hour");
    press(0, 0, 1, 1, "R4 hour 00 down to 23, R11 minutes kept");
    press(0, 1, 0, 1, "R3 hour 23 up to 00");
    for (int k = 0; k < 10; k++) press(0, 1, 0, 1, "R3 hour up with carry");
    press(0, 0, 1, 1, "R4 hour 10 down to 09");
    press(0, 1, 0, 4, "R9 held up steps once");
    press(0, 1, 1, 1, "R8 up and down together");

    press(1, 0, 0, 1, "R2 hour to minute");
    press(0, 0, 1, 1, "R6 minute 00 down to 59, R11 hours kept");
    press(0, 1, 0, 1, "R5 minute 59 up to 00");
    for (int k = 0; k < 10; k++) press(0, 1, 0, 1, "R5 minute up with carry");
    press(0, 0, 1, 1, "R6 minute 10 down to 09");
    press(0, 0, 1, 3, "R9 held down steps once");
    press(0, 1, 1, 2, "R8 simultaneous in minute mode");

    press(1, 0, 0, 1, "R2 minute to idle");
    press(0, 1, 0, 1, "R7 up ignored in idle");
    press(0, 0, 1, 1, "R7 down ignored in idle");

    // Buzzer: match with enable, then break each condition
    @(negedge clk); drive_cur(m_hr, m_mn); alarm_en = 1'b1; #1 push("R10 match and enabled");
    @(negedge clk); alarm_en = 1'b0; #1 push("R10 enable low");
    @(negedge clk); alarm_en = 1'b1; drive_cur((m_hr + 10) % 24, m_mn); #1 push("R10 hour tens differ");
    @(negedge clk); drive_cur(m_hr, (m_mn / 10) * 10 + (m_mn % 10 + 1) % 10); #1 push("R10 minute units differ");
    @(negedge clk); drive_cur(m_hr, (m_mn + 10) % 60); #1 push("R10 minute tens differ");
    @(negedge clk); drive_cur(m_hr, m_mn); #1 push("R10 match again");

    press(1, 0, 0, 5, "R2 held set advances once");
    press(0, 1, 0, 1, "R3 hour step after held set");
    do_reset("R1 reset mid-run");

    @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule